// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a per-processor timer that counts down from a loaded value at a rate set by a power-of-two clock divider. When the count runs out, the block raises a one-cycle expiry request that carries a programmed interrupt vector. The mask bit suppresses that request. The timer runs either once and then rests at zero, or repeatedly, reloading itself after each pass through zero.

Software reaches the block through a single-cycle write port with three targets: the load value, the divider setting and a control word. The control word holds the vector in bits 7:0, the mask in bit 16 and the repeat selector in bit 17. The current count can be read at any time on a registered output. The block does no vector prioritisation and has no bus adapter. A neighbouring interrupt controller consumes the expiry request.

Top module: `irq_countdown_timer`

## Requirements
- R1: A synchronous reset clears the count to 0, stops the timer, drops the expiry pulse and selects a divide-by-2 rate.
- R2: Only bits 0, 1 and 3 of a divider write are kept. The 3-bit code {bit3, bit1, bit0} selects a shift of (code + 1) mod 8. A write of 0xB therefore gives divide-by-1, 0x0 gives divide-by-2, 0x1 gives divide-by-4 and 0x8 gives divide-by-32. Other bits have no effect.
- R3: A load-value write (select 0) places the value on the count one clock later and restarts the divider phase. The first decrement comes one full divider period after the write edge.
- R4: In one-shot mode (control bit 17 = 0) the count falls by one per divider period and rests at 0 once the load value has elapsed.
- R5: In one-shot mode an unmasked expiry is a pulse exactly one cycle long, raised together with the count reaching 0. The programmed vector is presented alongside it.
- R6: In repeat mode (bit 17 = 1) the count passes through load+1 values per period, from load down to 0 and then back to load. An unmasked pulse comes at each step from 0 back to load.
- R7: With the mask bit (bit 16) set, counting proceeds unchanged but no expiry pulse is raised.
- R8: A load value of 0 stops the timer. The count stays 0 and no expiry is raised.
- R9: A control-word write (select 2) re-evaluates whether the timer runs. A one-shot timer that has finished resumes at the next divider tick when it is switched to repeat mode, wrapping from 0 to the load value.
- R10: A divider change takes effect from the next divider tick (or from that same tick when the two coincide) and does not disturb the count.
- R11: Writes with select 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 load value, 1 divider, 2 control word, 3 unused |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count (registered) |
| fire_o | output | 1 | One-cycle expiry request |
| fire_vec_o | output | VEC_W | Vector accompanying fire_o |

## Verification
A write sampled at clock edge E updates the count at E, so the new value is visible in the cycle that follows. With a divider period of D cycles, the count seen after edge E+j is a function of j/D, and the expiry pulse is visible in the cycle after the edge on which the count reaches 0 or wraps. The scoreboard therefore records each expected count, pulse and vector against the falling-edge index at which it becomes visible after its write edge. A monitor compares the design's outputs on exactly those falling edges. Register updates and tick-boundary effects such as divider changes and restarts are therefore checked on the exact cycle rather than within a tolerance window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int VEC_W       = 8;
  localparam int SHIFT_W     = 3;
  localparam int DIVCFG_W    = 4;
  localparam int CTL_MASK_BIT = 16;
  localparam int CTL_PER_BIT  = 17;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } tmr_ctl_t;

  // Divider code {b3,b1,b0}; shift = code + 1, wrapping in three bits.
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIVCFG_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + SHIFT_W'(1);
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               init_wr,
  output logic [CNT_W-1:0]   init_q,
  output logic               div_wr,
  output logic [SHIFT_W-1:0] div_shift_new,
  output logic [SHIFT_W-1:0] shift_pend,
  output tmr_ctl_t           ctl_q
);

  tmr_sel_e sel;
  logic     ctl_wr;

  assign sel           = tmr_sel_e'(wr_sel);
  assign init_wr       = wr_en && (sel == SEL_INIT);
  assign div_wr        = wr_en && (sel == SEL_DIV);
  assign ctl_wr        = wr_en && (sel == SEL_CTL);
  assign div_shift_new = div_to_shift(wr_data[DIVCFG_W-1:0] & DIVCFG_W'(4'hB));

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q     <= '0;
      shift_pend <= div_to_shift('0);
      ctl_q      <= '0;
    end else begin
      if (init_wr) init_q <= wr_data;
      if (div_wr)  shift_pend <= div_shift_new;
      if (ctl_wr) begin
        ctl_q.vec      <= wr_data[VEC_W-1:0];
        ctl_q.mask     <= wr_data[CTL_MASK_BIT];
        ctl_q.periodic <= wr_data[CTL_PER_BIT];
      end
    end
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          div_wr,
  input  logic [SW-1:0] div_shift_new,
  input  logic [SW-1:0] shift_pend,
  output logic          tick
);

  localparam int PRE_W = (1 << SW) - 1;

  logic [SW-1:0]    shift_act;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;
  logic [SW-1:0]    shift_next;

  assign limit      = PRE_W'((32'd1 << shift_act) - 32'd1);
  assign tick       = (pre_cnt == limit) && !restart;
  // A divider written on the boundary edge applies from that boundary on.
  assign shift_next = div_wr ? div_shift_new : shift_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt   <= '0;
      shift_act <= SW'(1);
    end else if (restart || tick) begin
      pre_cnt   <= '0;
      shift_act <= shift_next;
    end else begin
      pre_cnt   <= pre_cnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             init_wr,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] init_q,
  input  tmr_ctl_t         ctl_q,
  output logic [CNT_W-1:0] count_q,
  output logic             fire_q,
  output logic [VEC_W-1:0] vec_q
);

  logic running;
  logic at_zero;

  assign at_zero = (count_q == '0);
  assign running = (init_q != '0) && (ctl_q.periodic || !at_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      fire_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      fire_q <= 1'b0;
      if (init_wr) begin
        count_q <= init_val;
      end else if (tick && running) begin
        if (at_zero) begin
          count_q <= init_q;
          fire_q  <= !ctl_q.mask;
          vec_q   <= ctl_q.vec;
        end else begin
          count_q <= count_q - CNT_W'(1);
          if (!ctl_q.periodic && count_q == CNT_W'(1)) begin
            fire_q <= !ctl_q.mask;
            vec_q  <= ctl_q.vec;
          end
        end
      end
    end
  end

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o,
  output logic [VEC_W-1:0] fire_vec_o
);

  logic               init_wr;
  logic [CNT_W-1:0]   init_q;
  logic               div_wr;
  logic [SHIFT_W-1:0] div_shift_new;
  logic [SHIFT_W-1:0] shift_pend;
  tmr_ctl_t           ctl_q;
  logic               tick;
  logic               ctl_mask;

  assign ctl_mask = ctl_q.mask;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_wr(init_wr), .init_q(init_q), .div_wr(div_wr),
    .div_shift_new(div_shift_new), .shift_pend(shift_pend), .ctl_q(ctl_q)
  );

  tmr_prescale #(.SW(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .restart(init_wr), .div_wr(div_wr),
    .div_shift_new(div_shift_new), .shift_pend(shift_pend), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .init_wr(init_wr), .init_val(wr_data),
    .init_q(init_q), .ctl_q(ctl_q), .count_q(count_o), .fire_q(fire_o),
    .vec_q(fire_vec_o)
  );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_o,
  input logic             fire_o,
  input logic             mask_q
);

  logic init_wr;
  assign init_wr = wr_en && (wr_sel == 2'd0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0 && !fire_o));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);

  // R7
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> !$past(mask_q));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(init_wr) && count_o != $past(count_o)) |->
      ($past(count_o) == '0 || count_o == $past(count_o) - CNT_W'(1)));

  // R8
  zero_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (init_wr && wr_data == '0) |=> (count_o == '0 && !fire_o));

endmodule

bind irq_countdown_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .count_o(count_o), .fire_o(fire_o), .mask_q(ctl_mask)
);

// File: tb/irq_countdown_timer_bench.sv
module irq_countdown_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        fire_o;
  logic [7:0]  fire_vec_o;

  irq_countdown_timer u_irq_countdown_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .fire_o(fire_o), .fire_vec_o(fire_vec_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] cnt;
    logic        fire;
    logic [7:0]  vec;
    string       tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  logic [7:0] exp_vec = 8'h00;
  bit         done = 1'b0;

  // Monitor: one falling edge = one cycle index; compare due items.
  always @(negedge clk) begin
    cyc = cyc + 1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (it.due < cyc) begin
        fails++;
        $display("FAIL %s missed sample at cycle %0d: actual none expected cnt=%0d", it.tag, it.due, it.cnt);
      end else if (count_o !== it.cnt || fire_o !== it.fire ||
                   (it.fire && fire_vec_o !== it.vec)) begin
        fails++;
        $display("FAIL %s cycle %0d: actual cnt=%0d fire=%0b vec=%0h expected cnt=%0d fire=%0b vec=%0h",
                 it.tag, cyc, count_o, fire_o, fire_vec_o, it.cnt, it.fire, it.vec);
      end
    end
  end

  task automatic push(input int due, input logic [31:0] c, input logic f, input string tag);
    exp_t it;
    it.due = due; it.cnt = c; it.fire = f; it.vec = exp_vec; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int base);
    @(negedge clk); #1;
    base = cyc;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain;
    do begin
      @(negedge clk); #2;
    end while (sb.size() > 0);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) begin
      @(negedge clk); #1;
    end
  endtask

  function automatic logic [31:0] ctlw(input logic [7:0] v, input logic m, input logic p);
    return {14'd0, p, m, 8'd0, v};
  endfunction

  // Expected outputs after write edge E+j for j = 0..jmax.
  task automatic plan_run(input int base, input int n, input int d, input bit per,
                          input bit msk, input int jmax, input string tag);
    for (int j = 0; j <= jmax; j++) begin
      int t;
      logic [31:0] c;
      logic f;
      t = j / d;
      if (per) begin
        c = 32'(n - (t % (n + 1)));
        f = !msk && j > 0 && (j % d == 0) && (t % (n + 1) == 0);
      end else begin
        c = (t >= n) ? 32'd0 : 32'(n - t);
        f = !msk && n > 0 && (j == n * d);
      end
      push(base + 1 + j, c, f, tag);
    end
  endtask

  initial begin
    int b, b2;
    // R1: state while reset is held and just after release
    repeat (3) @(negedge clk);
    #1;
    push(cyc + 1, 32'd0, 1'b0, "R1");
    @(negedge clk); #1;
    rst = 1'b0;
    push(cyc + 2, 32'd0, 1'b0, "R1");
    drain();

    // R4 R5 R2: one-shot, divide 0xFFFFFFFB -> code 7 -> every clock
    exp_vec = 8'h41;
    wr(2'd1, 32'hFFFF_FFFB, b);
    wr(2'd2, ctlw(8'h41, 1'b0, 1'b0), b);
    wr(2'd0, 32'd5, b);
    plan_run(b, 5, 1, 0, 0, 8, "R4_R5_div1");
    drain();

    // R2: masked write 0xFFFFFFF4 -> code 0 -> divide by 2
    wr(2'd1, 32'hFFFF_FFF4, b);
    wr(2'd0, 32'd3, b);
    plan_run(b, 3, 2, 0, 0, 9, "R2_div2");
    drain();

    // R2: 0x8 -> code 4 -> divide by 32
    wr(2'd1, 32'h8, b);
    wr(2'd0, 32'd2, b);
    plan_run(b, 2, 32, 0, 0, 70, "R2_div32");
    drain();

    // R6: repeat mode, divide by 1
    exp_vec = 8'h22;
    wr(2'd1, 32'hB, b);
    wr(2'd2, ctlw(8'h22, 1'b0, 1'b1), b);
    wr(2'd0, 32'd2, b);
    plan_run(b, 2, 1, 1, 0, 9, "R6_periodic");
    drain();

    // R7: masked repeat mode counts but never fires
    wr(2'd2, ctlw(8'h22, 1'b1, 1'b1), b);
    wr(2'd0, 32'd1, b);
    plan_run(b, 1, 1, 1, 1, 6, "R7_mask");
    drain();

    // R8: load 0 stops a running timer
    wr(2'd0, 32'd0, b);
    plan_run(b, 0, 1, 0, 1, 5, "R8_zero");
    drain();

    // R11: select 3 is ignored
    wr(2'd3, 32'd5, b);
    plan_run(b, 0, 1, 0, 1, 4, "R11_unused");
    drain();

    // R9: finished one-shot resumes after switch to repeat
    exp_vec = 8'h33;
    wr(2'd2, ctlw(8'h33, 1'b0, 1'b0), b);
    wr(2'd0, 32'd2, b);
    plan_run(b, 2, 1, 0, 0, 4, "R9_oneshot");
    wait_until(b + 5);
    wr(2'd2, ctlw(8'h33, 1'b0, 1'b1), b2);
    push(b2 + 1, 32'd0, 1'b0, "R9_resume");
    push(b2 + 2, 32'd2, 1'b1, "R9_resume");
    push(b2 + 3, 32'd1, 1'b0, "R9_resume");
    push(b2 + 4, 32'd0, 1'b0, "R9_resume");
    push(b2 + 5, 32'd2, 1'b1, "R9_resume");
    drain();
    wr(2'd0, 32'd0, b);
    drain();

    // R10: divide change on the edge after the load, count kept
    wr(2'd2, ctlw(8'h33, 1'b0, 1'b0), b);
    wr(2'd0, 32'd10, b);
    push(b + 1, 32'd10, 1'b0, "R10_load");
    wr(2'd1, 32'hFFFF_FFF4, b2);
    for (int j = 0; j <= 5; j++) push(b2 + 1 + j, 32'(9 - j / 2), 1'b0, "R10_newdiv");
    drain();
    wr(2'd0, 32'd0, b);
    drain();

    // R3: reload restarts the divider phase (divide by 4)
    wr(2'd1, 32'h1, b);
    wr(2'd0, 32'd3, b);
    plan_run(b, 3, 4, 0, 0, 4, "R3_first");
    wait_until(b + 5);
    wr(2'd0, 32'd7, b2);
    plan_run(b2, 7, 4, 0, 0, 9, "R3_restart");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule